// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block turns a selectable input clock into a frame sync pulse train, one per channel. Each channel picks its input from one of two external lines or from the peripheral clock. It then does one of two things. In strobe mode it divides that input by a programmable divisor and holds its output high for a programmable number of input periods at the start of each frame. In pass-through mode it forwards the input unchanged or inverted.

The block runs on a single system clock. Each selected input is synchronised to that clock, and its rising edges act as a count enable. It never clocks any register directly. Software programs the block through a plain write port with three word addresses. Address 0 holds both pulse widths. Address 1 is the control word of channel A (output bit 0). Address 2 is the control word of channel B (output bit 1).

Top module: `fsync_gen`

## Requirements
- R1: While reset is asserted, and after it is released, both outputs are low. After reset both channels are in pass-through mode, not inverted, and take their input from `ext_src[0]`.
- R2: In pass-through mode (control bit 16 = 0, invert bit 17 = 0), `fs_out[ch]` equals the selected input as it was two system clocks earlier.
- R3: In pass-through mode with control bit 17 = 1, `fs_out[ch]` equals the inverse of the selected input as it was two system clocks earlier.
- R4: In strobe mode (control bit 16 = 1) with divisor D ≥ 2 (control bits 15:0) and width W < D, the output has period D·P system clocks and stays high for W·P clocks, where P is the input period in system clocks.
- R5: In strobe mode with W ≥ D ≥ 2, the width is clamped to D−1. The output stays high for (D−1)·P clocks and low for P clocks. The output is never high in the cycle after the counter sits on its last value.
- R6: In strobe mode, a divisor of 0 or 1 keeps the output low.
- R7: In strobe mode, a width of 0 keeps the output low.
- R8: Control bit 18 selects the input: 0 takes `ext_src[0]` and 1 takes `ext_src[1]`.
- R9: Control bit 19 set makes the peripheral clock the input, whatever bit 18 holds.
- R10: The width word at address 0 carries channel A's width in bits 15:0 and channel B's width in bits 31:16. Each channel uses only its own field.
- R11: A write to a channel's control word, or to the width word, restarts that channel's counter at 0 on the next input edge. The output then rises within one input period plus a few system clocks, even if the write lands in the middle of a low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Word address: 0 widths, 1 control A, 2 control B |
| cfg_wdata | input | 32 | Configuration write data |
| ext_src | input | 2 | External input clock candidates |
| periph_clk | input | 1 | Peripheral clock, used when the override bit is set |
| fs_out | output | 2 | Frame sync outputs, bit 0 channel A, bit 1 channel B |

## Verification
Pass-through results appear two system clocks after the input changes: one clock for the input synchroniser and one for the output register. The bench therefore compares each output with the input value it captured two falling edges earlier. Strobe-mode results follow a fixed pipeline behind each input edge. Because that latency is constant, the bench measures high time and period between output edges in system clocks and compares them with W·P and D·P. It measures only after a settling wait of two frames following each write. The restart check counts the clocks from a write until the next rising output edge and bounds that count well below the time left in the old frame.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  localparam int FS_NUM_CH  = 2;
  localparam int FS_CNT_W   = 16;
  localparam int FS_DATA_W  = 32;
  localparam int FS_ADDR_W  = 2;
  localparam int FS_N_EXT   = 2;
  localparam int FS_SEL_W   = $clog2(FS_N_EXT);

  // control word layout
  localparam int CTL_DIV_LSB = 0;
  localparam int CTL_STB_BIT = 16;
  localparam int CTL_INV_BIT = 17;
  localparam int CTL_SEL_LSB = 18;
  localparam int CTL_OVR_BIT = CTL_SEL_LSB + FS_SEL_W;

  // word addresses: width word at 0, control of channel n at n+1
  localparam int ADDR_WIDTH_WORD = 0;
  localparam int ADDR_CTRL_BASE  = 1;
endpackage

// File: rtl/fsync_cfg_regs.sv
module fsync_cfg_regs
  import fsync_pkg::*;
#(
  parameter int NUM_CH = FS_NUM_CH,
  parameter int CNT_W  = FS_CNT_W,
  parameter int DATA_W = FS_DATA_W,
  parameter int ADDR_W = FS_ADDR_W,
  parameter int SEL_W  = FS_SEL_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NUM_CH-1:0][CNT_W-1:0]  div,
  output logic [NUM_CH-1:0][CNT_W-1:0]  pw,
  output logic [NUM_CH-1:0]             stb,
  output logic [NUM_CH-1:0]             inv,
  output logic [NUM_CH-1:0][SEL_W-1:0]  sel,
  output logic [NUM_CH-1:0]             ovr,
  output logic [NUM_CH-1:0]             restart
);
  localparam int PW_W = DATA_W / NUM_CH;

  logic [NUM_CH-1:0][CNT_W-1:0] div_nxt, pw_nxt;
  logic [NUM_CH-1:0]            stb_nxt, inv_nxt, ovr_nxt, restart_nxt;
  logic [NUM_CH-1:0][SEL_W-1:0] sel_nxt;

  always_comb begin
    div_nxt     = div;
    pw_nxt      = pw;
    stb_nxt     = stb;
    inv_nxt     = inv;
    sel_nxt     = sel;
    ovr_nxt     = ovr;
    restart_nxt = '0;
    if (we) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (addr == ADDR_W'(ADDR_WIDTH_WORD)) begin
          pw_nxt[ch]      = wdata[ch*PW_W +: CNT_W];
          restart_nxt[ch] = 1'b1;
        end else if (addr == ADDR_W'(ADDR_CTRL_BASE + ch)) begin
          div_nxt[ch]     = wdata[CTL_DIV_LSB +: CNT_W];
          stb_nxt[ch]     = wdata[CTL_STB_BIT];
          inv_nxt[ch]     = wdata[CTL_INV_BIT];
          sel_nxt[ch]     = wdata[CTL_SEL_LSB +: SEL_W];
          ovr_nxt[ch]     = wdata[CTL_OVR_BIT];
          restart_nxt[ch] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div     <= '0;
      pw      <= '0;
      stb     <= '0;
      inv     <= '0;
      sel     <= '0;
      ovr     <= '0;
      restart <= '0;
    end else begin
      div     <= div_nxt;
      pw      <= pw_nxt;
      stb     <= stb_nxt;
      inv     <= inv_nxt;
      sel     <= sel_nxt;
      ovr     <= ovr_nxt;
      restart <= restart_nxt;
    end
  end
endmodule

// File: rtl/fsync_src_sel.sv
module fsync_src_sel
  import fsync_pkg::*;
#(
  parameter int N_EXT = FS_N_EXT,
  parameter int SEL_W = FS_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_src,
  input  logic              periph_clk,
  input  logic [SEL_W-1:0]  sel,
  input  logic              ovr,
  output logic              in_q,
  output logic              tick
);
  logic raw, in_q_nxt, in_d, in_d_nxt;

  // override has priority over the ordinary select
  always_comb begin
    raw      = ovr ? periph_clk : ext_src[sel];
    in_q_nxt = raw;
    in_d_nxt = in_q;
    tick     = in_q & ~in_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= 1'b0;
      in_d <= 1'b0;
    end else begin
      in_q <= in_q_nxt;
      in_d <= in_d_nxt;
    end
  end
endmodule

// File: rtl/fsync_chan.sv
module fsync_chan
  import fsync_pkg::*;
#(
  parameter int CNT_W = FS_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             in_q,
  input  logic             stb,
  input  logic             inv,
  input  logic             restart,
  input  logic [CNT_W-1:0] div,
  input  logic [CNT_W-1:0] pw,
  output logic             fs,
  output logic [CNT_W-1:0] cnt,
  output logic             pend
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] last, eff_pw, cnt_nxt;
  logic             div_ok, pend_nxt, fs_nxt;

  always_comb begin
    div_ok = (div >= TWO);
    last   = div - ONE;
    eff_pw = (pw > last) ? last : pw;
  end

  always_comb begin
    cnt_nxt  = cnt;
    pend_nxt = pend | restart;
    if (!stb) begin
      cnt_nxt  = '0;
      pend_nxt = 1'b1;
    end else if (tick) begin
      pend_nxt = 1'b0;
      if (pend || restart)  cnt_nxt = '0;
      else if (cnt >= last) cnt_nxt = '0;
      else                  cnt_nxt = cnt + ONE;
    end
    fs_nxt = stb ? (div_ok && (cnt < eff_pw)) : (in_q ^ inv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b1;
      fs   <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      pend <= pend_nxt;
      fs   <= fs_nxt;
    end
  end
endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
  import fsync_pkg::*;
#(
  parameter int NUM_CH = FS_NUM_CH,
  parameter int CNT_W  = FS_CNT_W,
  parameter int DATA_W = FS_DATA_W,
  parameter int ADDR_W = FS_ADDR_W,
  parameter int N_EXT  = FS_N_EXT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [N_EXT-1:0]  ext_src,
  input  logic              periph_clk,
  output logic [NUM_CH-1:0] fs_out
);
  localparam int SEL_W = $clog2(N_EXT);

  logic [NUM_CH-1:0][CNT_W-1:0] div_w, pw_w, cnt_w;
  logic [NUM_CH-1:0][SEL_W-1:0] sel_w;
  logic [NUM_CH-1:0]            stb_w, inv_w, ovr_w, rst_req_w;
  logic [NUM_CH-1:0]            inq_w, tick_w, pend_w;

  fsync_cfg_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .div(div_w), .pw(pw_w), .stb(stb_w), .inv(inv_w), .sel(sel_w), .ovr(ovr_w),
    .restart(rst_req_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    fsync_src_sel #(.N_EXT(N_EXT), .SEL_W(SEL_W)) u_src (
      .clk(clk), .rst_n(rst_n), .ext_src(ext_src), .periph_clk(periph_clk),
      .sel(sel_w[g]), .ovr(ovr_w[g]), .in_q(inq_w[g]), .tick(tick_w[g])
    );

    fsync_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick_w[g]), .in_q(inq_w[g]),
      .stb(stb_w[g]), .inv(inv_w[g]), .restart(rst_req_w[g]),
      .div(div_w[g]), .pw(pw_w[g]), .fs(fs_out[g]), .cnt(cnt_w[g]), .pend(pend_w[g])
    );
  end
endmodule

// File: rtl/fsync_gen_chk.sv
module fsync_gen_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            stb,
  input logic [NUM_CH-1:0]            inv,
  input logic [NUM_CH-1:0][CNT_W-1:0] div,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CH-1:0]            in_q,
  input logic [NUM_CH-1:0]            tick,
  input logic [NUM_CH-1:0]            pend,
  input logic [NUM_CH-1:0]            fs
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_reset_low_r1: assert property (@(posedge clk)
      !rst_n |=> !fs[g]);

    // pass-through, both polarities (R2 and R3)
    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!stb[g]) |-> (fs[g] == ($past(in_q[g]) ^ $past(inv[g]))));

    p_clamp_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stb[g] && (div[g] >= TWO) && (cnt[g] >= div[g] - ONE)) |-> !fs[g]);

    p_div_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stb[g] && (div[g] < TWO)) |-> !fs[g]);

    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stb[g] && tick[g] && pend[g]) |-> (cnt[g] == '0));
  end
endmodule

bind fsync_gen fsync_gen_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb(stb_w), .inv(inv_w), .div(div_w), .cnt(cnt_w),
  .in_q(inq_w), .tick(tick_w), .pend(pend_w), .fs(fs_out)
);

// File: tb/fsync_gen_tb.sv
module fsync_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [1:0]  ext_src = 2'b00;
  logic        periph_clk = 1'b0;
  logic [1:0]  fs_out;

  int checks = 0;
  int failures = 0;
  int gcyc = 0;
  int wd = 0;
  int pw_a = 0;
  int pw_b = 0;

  fsync_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ext_src(ext_src), .periph_clk(periph_clk), .fs_out(fs_out)
  );

  always #10 clk = ~clk;

  // input clocks: ext0 period 4, ext1 period 6, periph period 10 (system clocks)
  always @(posedge clk) begin
    gcyc       <= gcyc + 1;
    ext_src[0] <= (gcyc % 4) < 2;
    ext_src[1] <= (gcyc % 6) < 3;
    periph_clk <= (gcyc % 10) < 5;
  end

  always @(negedge clk) begin
    wd++;
    if (wd > 150000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000", wd);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int src_period(input int src);
    return (src == 0) ? 4 : (src == 1) ? 6 : 10;
  endfunction

  function automatic int exp_width(input int pw, input int dv);
    return (pw >= dv) ? dv - 1 : pw;
  endfunction

  function automatic logic [31:0] ctrl(input int dv, input bit st, input bit iv,
                                       input bit sl, input bit ov);
    return {12'd0, ov, sl, iv, st, dv[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_width(input int a, input int b);
    pw_a = a; pw_b = b;
    cfg_write(2'd0, {b[15:0], a[15:0]});
  endtask

  function automatic logic src_val(input int src);
    return (src == 0) ? ext_src[0] : (src == 1) ? ext_src[1] : periph_clk;
  endfunction

  // output must equal (input ^ inv) as seen two falling edges earlier
  task automatic check_pass(input int ch, input int src, input bit iv, input string tag);
    logic h1, h2;
    int bad = 0;
    int act = 0, exp = 0;
    repeat (6) @(negedge clk);
    h2 = src_val(src); @(negedge clk);
    h1 = src_val(src); @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      if (fs_out[ch] !== (h2 ^ iv) && bad == 0) begin
        bad = 1; act = int'(fs_out[ch]); exp = int'(h2 ^ iv);
      end
      h2 = h1; h1 = src_val(src);
      @(negedge clk);
    end
    chk(bad == 0, tag, act, exp);
  endtask

  task automatic measure(input int ch, output int hi, output int per);
    int t = 0, lo = 0;
    hi = -1; per = -1;
    while (fs_out[ch] !== 1'b0 && t < 600) begin @(negedge clk); t++; end
    while (fs_out[ch] !== 1'b1 && t < 600) begin @(negedge clk); t++; end
    if (t >= 600) return;
    hi = 0;
    while (fs_out[ch] === 1'b1 && hi < 600) begin @(negedge clk); hi++; end
    while (fs_out[ch] === 1'b0 && lo < 600) begin @(negedge clk); lo++; end
    per = hi + lo;
  endtask

  task automatic check_strobe(input int ch, input int ehi, input int eper, input string tag);
    int hi, per;
    repeat (2 * eper + 10) @(negedge clk);
    measure(ch, hi, per);
    chk(hi == ehi, {tag, " high time"}, hi, ehi);
    chk(per == eper, {tag, " period"}, per, eper);
  endtask

  task automatic check_low(input int ch, input int n, input string tag);
    int highs = 0;
    repeat (12) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (fs_out[ch] !== 1'b0) highs++;
      @(negedge clk);
    end
    chk(highs == 0, tag, highs, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    chk(fs_out == 2'b00, "R1 outputs low in reset", int'(fs_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fs_out == 2'b00, "R1 outputs low after release", int'(fs_out), 0);
    check_pass(0, 0, 1'b0, "R1 default pass-through A");
    check_pass(1, 0, 1'b0, "R1 default pass-through B");

    // pass-through polarity and selection
    cfg_write(2'd2, ctrl(0, 0, 1, 0, 0));
    check_pass(1, 0, 1'b1, "R3 inverted pass-through B");
    check_pass(0, 0, 1'b0, "R2 channel A unaffected");
    cfg_write(2'd1, ctrl(0, 0, 0, 1, 0));
    check_pass(0, 1, 1'b0, "R8 pass-through from ext_src[1]");
    cfg_write(2'd1, ctrl(0, 0, 0, 1, 1));
    check_pass(0, 2, 1'b0, "R9 override to peripheral clock");

    // strobe mode, field positions
    set_width(2, 3);
    cfg_write(2'd1, ctrl(5, 1, 0, 0, 0));
    cfg_write(2'd2, ctrl(5, 1, 0, 0, 0));
    check_strobe(0, 8, 20, "R4 A D=5 W=2");
    check_strobe(1, 12, 20, "R10 B uses bits 31:16");

    set_width(2, 1);
    cfg_write(2'd2, ctrl(3, 1, 0, 1, 0));
    check_strobe(1, 6, 18, "R8 strobe from ext_src[1]");
    set_width(1, 1);
    cfg_write(2'd1, ctrl(3, 1, 0, 1, 1));
    check_strobe(0, 10, 30, "R9 override wins over select");

    set_width(9, 1);
    cfg_write(2'd1, ctrl(4, 1, 0, 0, 0));
    check_strobe(0, 12, 16, "R5 clamp W>=D");

    cfg_write(2'd1, ctrl(1, 1, 0, 0, 0));
    check_low(0, 60, "R6 divisor 1 keeps low");
    cfg_write(2'd1, ctrl(0, 1, 1, 0, 0));
    check_low(0, 60, "R6 divisor 0 keeps low");
    set_width(0, 1);
    cfg_write(2'd1, ctrl(4, 1, 0, 0, 0));
    check_low(0, 60, "R7 width 0 keeps low");

    // restart on write, in mid low phase
    begin
      int t = 0;
      set_width(2, 1);
      cfg_write(2'd1, ctrl(8, 1, 0, 0, 0));
      repeat (80) @(negedge clk);
      while (fs_out[0] !== 1'b1) @(negedge clk);
      while (fs_out[0] !== 1'b0) @(negedge clk);
      repeat (4) @(negedge clk);
      set_width(2, 1);
      while (fs_out[0] !== 1'b1 && t < 100) begin @(negedge clk); t++; end
      chk(t <= 10, "R11 restart after write", t, 10);
    end

    // constrained random configurations
    for (int k = 0; k < 12; k++) begin
      int ch  = int'($urandom % 2);
      int src = int'($urandom % 3);
      int dv  = 2 + int'($urandom % 6);
      int pw  = int'($urandom % 9);
      int p   = src_period(src);
      int ew  = exp_width(pw, dv);
      if (ch == 0) set_width(pw, pw_b); else set_width(pw_a, pw);
      cfg_write(2'(ch + 1), ctrl(dv, 1, 0, src == 1, src == 2));
      if (ew == 0) check_low(ch, 2 * dv * p + 20, "R7 random zero width");
      else         check_strobe(ch, ew * p, dv * p, "R4 random strobe");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule